// File: doc/BRIEF.md
# Oversampled Manchester Receiver with Bit-Timing Recovery

This block takes a Manchester-coded serial line sampled by the system clock at ten samples per bit. It returns the decoded NRZ data, a bit-rate clock aligned to that data, and a one-cycle strobe at the centre of each decoded bit. Every clock it pushes the line sample into a sliding window of the most recent N samples, and that window is also presented as a parallel output. A detector reports a transition sitting in the middle of the window: five equal samples followed by five of the opposite level.

A tracking state machine watches those reports. It searches for three transitions exactly one bit period apart, with no other transition between them. Only mid-bit transitions can do that, so a bit-boundary transition is never mistaken for one. Once it has locked, a free-running phase counter marks where each mid-bit transition is expected, and transitions at other phases are ignored. A few missing transitions are tolerated. Four in a row drop the lock, and the search starts again.

Bits use the convention that 0 is sent low then high, so a decoded bit is the inverse of the level in its second half. The recovered clock and the strobe stay low whenever the block is not locked.

Top module: `manch_rx_recover`

## Requirements
- R1: On every clock with `rst_n` high, `sample_win[N-1]` takes `rx_line`, and each other bit `sample_win[i]` takes the old `sample_win[i+1]`. The newest sample is always at the most significant bit.
- R2: While `rst_n` is low at a rising clock edge, the window clears to zero, `rec_data`, `rec_clk` and `rec_strobe` go to 0, and the tracker returns to searching. `rx_line` is ignored during that time.
- R3: A transition is detected when the window's N/2 oldest samples are all equal and its N/2 newest samples all hold the opposite level. Lock is taken at the third of three detected transitions spaced exactly N clocks apart with no other detection between them. A fresh search needs all three of those transitions to arrive after the lock was lost.
- R4: A run of equal bits gives a detection every N/2 clocks, at bit boundaries as well as at mid-bit points. Such a run never produces lock.
- R5: `rec_data` is loaded with the inverse of the newest sample, one clock after the expected mid-bit detection point, at every bit period while locked and at the locking transition. A missing transition on an idle-low line loads 1. Bit 0 is sent low then high, bit 1 high then low.
- R6: While locked, `rec_strobe` is high for exactly one clock per bit period. That clock comes N/2 clocks after `rec_data` is loaded.
- R7: While locked, `rec_clk` is low for the first N/2 clocks of each recovered bit and high for the last N/2. It rises in the same clock as `rec_strobe`.
- R8: While locked, a detection at any other phase (for example a bit boundary between equal bits) has no effect. One to three consecutive missing transitions keep the lock and the bit-period timing.
- R9: The fourth consecutive missing transition drops the lock, starting one clock after that expected point.
- R10: `rec_clk` and `rec_strobe` are low whenever the block is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, N samples per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Manchester-coded serial line |
| sample_win | output | N | Window of the last N samples, newest at MSB |
| rec_data | output | 1 | Recovered NRZ data |
| rec_clk | output | 1 | Recovered bit clock, rises at mid-bit |
| rec_strobe | output | 1 | One-clock strobe at the centre of each recovered bit |

## Verification
The properties assume that `rx_line` is already synchronous to `clk`, and that while the block is locked the line keeps exactly N samples per bit, so the phase counter never has to slip. The bench drives one sample per clock on the falling edge and keeps to a fixed grid of bit slots. Each slot holds either a Manchester-coded bit or idle-low line. That grid keeps every transition on the phases the tracker expects, while random bits, runs of equal bits, short and long idle gaps and an alternating run still exercise searching, locking, ignored boundary transitions, tolerated misses and loss of lock.

// File: rtl/manch_rx_pkg.sv
// Shared types for the Manchester receiver.
// Assumes nothing beyond a single clock domain.
package manch_rx_pkg;

    // Tracking state: searching, acquiring (counting spaced hits), locked
    typedef enum logic [1:0] {
        TRK_SEARCH  = 2'd0,
        TRK_ACQUIRE = 2'd1,
        TRK_TRACK   = 2'd2
    } trk_state_t;

endpackage

// File: rtl/manch_rx_window.sv
// Sliding sample window: the newest line sample enters at the MSB and the
// older samples move one place toward bit 0 on each clock.
// Assumes the line input is already synchronous to clk.
module manch_rx_window #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_line,
    output logic [N-1:0] win
);

    // Shift the window right, inserting the new sample at the top
    always_ff @(posedge clk) begin
        if (!rst_n) win <= '0;
        else        win <= {rx_line, win[N-1:1]};
    end

endmodule

// File: rtl/manch_rx_edge_det.sv
// Centre-transition detector: flags a window whose older half is uniform and
// whose newer half is uniform at the opposite level.
// Assumes N is even, so the two halves are the same size.
module manch_rx_edge_det #(
    parameter int N = 10
) (
    input  logic [N-1:0] win,
    output logic         edge_seen,
    output logic         new_level
);

    localparam int HALF = N / 2;

    logic [HALF-1:0] older_half;
    logic [HALF-1:0] newer_half;

    // Split the window and test both uniform-halves patterns
    always_comb begin
        older_half = win[HALF-1:0];
        newer_half = win[N-1:HALF];
        edge_seen  = ((&older_half) && !(|newer_half)) ||
                     (!(|older_half) && (&newer_half));
        new_level  = win[N-1];
    end

endmodule

// File: rtl/manch_rx_tracker.sv
// Bit-timing tracker: acquires lock from evenly spaced centre transitions,
// then free-runs a phase counter, decodes one bit per period and drops lock
// after too many consecutive missing transitions.
// Assumes edge_seen/new_level come combinationally from the current window.
module manch_rx_tracker
    import manch_rx_pkg::*;
#(
    parameter int N          = 10,
    parameter int LOCK_HITS  = 3,
    parameter int MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    input  logic new_level,
    output logic rec_data,
    output logic rec_clk,
    output logic rec_strobe
);

    localparam int PW = $clog2(N);
    localparam int HW = $clog2(LOCK_HITS + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(N - 1);
    localparam logic [PW-1:0] PH_MID  = PW'(N / 2);
    localparam logic [HW-1:0] HIT_DONE = HW'(LOCK_HITS - 1);
    localparam logic [MW-1:0] MISS_DONE = MW'(MISS_LIMIT - 1);

    trk_state_t    state;
    logic [PW-1:0] phase;
    logic [HW-1:0] hits;
    logic [MW-1:0] misses;
    logic          at_mark;
    logic          locked;

    // Expected centre-transition point of the current bit period
    assign at_mark = (phase == PH_LAST);

    // State, phase, hit/miss counters and decoded bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TRK_SEARCH;
            phase    <= '0;
            hits     <= '0;
            misses   <= '0;
            rec_data <= 1'b0;
        end else begin
            case (state)
                TRK_SEARCH: begin
                    if (edge_seen) begin
                        state <= TRK_ACQUIRE;
                        phase <= '0;
                        hits  <= HW'(1);
                    end
                end
                TRK_ACQUIRE: begin
                    if (edge_seen) begin
                        phase <= '0;
                        if (at_mark) begin
                            hits <= hits + 1'b1;
                            if (hits == HIT_DONE) begin
                                state    <= TRK_TRACK;
                                misses   <= '0;
                                rec_data <= ~new_level;
                            end
                        end else begin
                            hits <= HW'(1);
                        end
                    end else if (at_mark) begin
                        state <= TRK_SEARCH;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                TRK_TRACK: begin
                    if (at_mark) begin
                        phase    <= '0;
                        rec_data <= ~new_level;
                        if (edge_seen)               misses <= '0;
                        else if (misses == MISS_DONE) state <= TRK_SEARCH;
                        else                         misses <= misses + 1'b1;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= TRK_SEARCH;
            endcase
        end
    end

    // Bit clock and centre strobe, both gated by lock
    always_comb begin
        locked     = (state == TRK_TRACK);
        rec_clk    = locked && (phase >= PH_MID);
        rec_strobe = locked && (phase == PH_MID);
    end

endmodule

// File: rtl/manch_rx_recover.sv
// Top of the Manchester receiver: sample window, centre-transition detector
// and bit-timing tracker.
// Assumes rx_line is synchronous to clk and carries N samples per bit.
module manch_rx_recover #(
    parameter int N          = 10,
    parameter int LOCK_HITS  = 3,
    parameter int MISS_LIMIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_line,
    output logic [N-1:0] sample_win,
    output logic         rec_data,
    output logic         rec_clk,
    output logic         rec_strobe
);

    logic edge_seen;
    logic new_level;

    manch_rx_window #(.N(N)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_line (rx_line),
        .win     (sample_win)
    );

    manch_rx_edge_det #(.N(N)) u_edge (
        .win       (sample_win),
        .edge_seen (edge_seen),
        .new_level (new_level)
    );

    manch_rx_tracker #(
        .N          (N),
        .LOCK_HITS  (LOCK_HITS),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_seen  (edge_seen),
        .new_level  (new_level),
        .rec_data   (rec_data),
        .rec_clk    (rec_clk),
        .rec_strobe (rec_strobe)
    );

endmodule

// File: rtl/manch_rx_recover_chk.sv
// Property checker for manch_rx_recover, attached with bind below.
// Assumes a line that keeps N samples per bit while locked.
module manch_rx_recover_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_line,
    input logic [N-1:0] sample_win,
    input logic         rec_data,
    input logic         rec_clk,
    input logic         rec_strobe
);

    // R1: window moves one place and takes the previous line sample at the top
    a_r1_window_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sample_win == {$past(rx_line), $past(sample_win[N-1:1])}));

    // R6: the strobe never lasts more than one clock
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rec_strobe |=> !rec_strobe);

    // R7: bit clock rises only together with the strobe
    a_r7_clk_rise_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_clk) |-> rec_strobe);

    // R7: bit clock is still high the clock after the strobe
    a_r7_clk_high_after: assert property (@(posedge clk) disable iff (!rst_n)
        rec_strobe |=> rec_clk);

    // R5: decoded data is steady at the centre of the bit
    a_r5_data_steady_mid: assert property (@(posedge clk) disable iff (!rst_n)
        rec_strobe |-> $stable(rec_data));

endmodule

bind manch_rx_recover manch_rx_recover_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .sample_win (sample_win),
    .rec_data   (rec_data),
    .rec_clk    (rec_clk),
    .rec_strobe (rec_strobe)
);

// File: tb/manch_rx_recover_tb.sv
// Bench for manch_rx_recover: slot-grid stimulus (random bits, equal-bit
// runs, idle gaps, alternating run) with per-cycle expected values.
module manch_rx_recover_tb_top;

    localparam int N    = 10;
    localparam int HALF = N / 2;
    localparam int MAXS = 160;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_line = 1'b0;
    logic [N-1:0] sample_win;
    logic         rec_data;
    logic         rec_clk;
    logic         rec_strobe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    bit    s_data [MAXS];
    bit    s_val  [MAXS];
    string s_tag  [MAXS];
    bit    s_lock [MAXS];
    int    n_slots = 0;

    always #2 clk = ~clk;

    manch_rx_recover #(.N(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .sample_win (sample_win),
        .rec_data   (rec_data),
        .rec_clk    (rec_clk),
        .rec_strobe (rec_strobe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic add_slot(input bit d, input bit v, input string t);
        s_data[n_slots] = d;
        s_val[n_slots]  = v;
        s_tag[n_slots]  = t;
        n_slots++;
    endtask

    // Line level for sample k: data bit b is b then ~b, idle is low
    function automatic logic smp(input int k);
        int j, i;
        if (k < 0) return 1'b0;
        j = k / N;
        i = k % N;
        if (!s_data[j]) return 1'b0;
        return (i < HALF) ? s_val[j] : ~s_val[j];
    endfunction

    // Expected lock after each slot, from the acquisition and miss rules
    function automatic void plan_lock();
        bit locked = 1'b0;
        int misses = 0;
        int unl = -1;
        for (int j = 0; j < n_slots; j++) begin
            if (!locked) begin
                if (j >= 2 && (j - 2) > unl && s_data[j] && s_data[j-1] && s_data[j-2] &&
                    s_val[j] != s_val[j-1] && s_val[j-1] != s_val[j-2]) begin
                    locked = 1'b1;
                    misses = 0;
                end
            end else if (!s_data[j]) begin
                misses++;
                if (misses == 4) begin
                    locked = 1'b0;
                    unl = j;
                end
            end else begin
                misses = 0;
            end
            s_lock[j] = locked;
        end
    endfunction

    // Per-cycle checks for last captured sample index q
    task automatic check_cycle(input int q);
        logic [N-1:0] ew;
        int  j, c;
        bit  lk;
        for (int i = 0; i < N; i++) ew[N-1-i] = smp(q - i);
        chk("R1 window", 32'(sample_win), 32'(ew));
        j  = q / N - 1;
        c  = q % N;
        lk = (j >= 0) ? s_lock[j] : 1'b0;
        if (lk) begin
            chk({"R7 rec_clk ", s_tag[j]}, 32'(rec_clk), 32'(c >= HALF));
            chk("R6 rec_strobe", 32'(rec_strobe), 32'(c == HALF));
            chk({"R5 rec_data ", s_tag[j]}, 32'(rec_data), 32'(s_data[j] ? s_val[j] : 1'b1));
        end else begin
            chk({"R10 rec_clk unlocked ", (j >= 0) ? s_tag[j] : "R3"}, 32'(rec_clk), 32'd0);
            chk("R10 rec_strobe unlocked", 32'(rec_strobe), 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int total;
        void'($urandom(32'd7331));
        // slot plan
        for (int i = 0; i < 2; i++)  add_slot(1'b0, 1'b0, "R3");
        for (int i = 0; i < 40; i++) add_slot(1'b1, 1'($urandom % 2), "R3");
        for (int i = 0; i < 12; i++) add_slot(1'b1, 1'b1, "R8");
        for (int i = 0; i < 3; i++)  add_slot(1'b0, 1'b0, "R8");
        for (int i = 0; i < 10; i++) add_slot(1'b1, 1'($urandom % 2), "R8");
        for (int i = 0; i < 6; i++)  add_slot(1'b0, 1'b0, "R9");
        for (int i = 0; i < 8; i++)  add_slot(1'b1, 1'b0, "R4");
        for (int i = 0; i < 6; i++)  add_slot(1'b1, 1'(i % 2), "R3");
        for (int i = 0; i < 20; i++) add_slot(1'b1, 1'($urandom % 2), "R3");
        add_slot(1'b0, 1'b0, "R9");
        plan_lock();

        // R2: reset with the line held high
        rx_line = 1'b1;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 window after reset", 32'(sample_win), 32'd0);
        chk("R2 rec_data after reset", 32'(rec_data), 32'd0);
        chk("R2 rec_clk after reset", 32'(rec_clk), 32'd0);
        chk("R2 rec_strobe after reset", 32'(rec_strobe), 32'd0);

        total = n_slots * N;
        rst_n   = 1'b1;
        rx_line = smp(0);
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            check_cycle(k - 1);
            if (k < total) rx_line = smp(k);
        end

        // Directed end-state checks tied to the segment rules
        chk("R4 no lock during equal-bit run", 32'(s_lock[73 + 7]), 32'd0);
        chk("R9 lock dropped after four misses", 32'(s_lock[67 + 4]), 32'd0);
        chk("R8 lock kept over three misses", 32'(s_lock[56]), 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule